// File: doc/BRIEF.md
# Circuit-Switched Ring Router Node

This block is one node of an on-chip ring network that also has chord links straight across the ring. It has four channels: left, right, across and the local processing element. Each channel has an inbound and an outbound port, and each port carries a request strobe, a release strobe, a data bus and a backward accept/reject pair. The router holds no packet storage. A request puts the destination node number on the data lines and claims one outbound port per hop. Once the claim is held, the same lines carry payload straight through until the source sends a release.

Each inbound port compares the destination with the node's own number. A matching request goes to the local element. A request that does not match keeps its direction of travel, and the router never bends it. The local element picks its outbound direction itself through a two-bit route code. Every outbound port has its own round-robin allocator. If the port is already held, the request is refused at once with a reject, and the source decides whether to retry. Accept and reject answers coming back from downstream are relayed to whichever inbound port holds the path.

Top module: `ring_cs_switch`

## Requirements
- R1: After reset every request, release, accept and reject output is low, every data output is zero, and no outbound port is held.
- R2: A request whose low ADDR_W data bits equal `localAddr` is steered to the local outbound port (index 3).
- R3: A non-matching request keeps its travel direction: left inbound (0) leaves on right (1), right inbound (1) on left (0), across inbound (2) on right (1). The local inbound request uses `peRoute`: 0 left, 1 right, 2 across, 3 refused with a reject.
- R4: A request for an outbound port that is already held produces a one-cycle reject on its inbound port in the next cycle and is not forwarded.
- R5: A granted request shows `reqOut` high, with the destination address on that port's data lines, in the cycle after it arrives (one cycle per hop).
- R6: An accept or reject arriving on a held outbound port appears on the holding inbound port one cycle later. A downstream reject also frees the outbound port.
- R7: While a path is held, the outbound data lines carry the holding inbound data one cycle later. An outbound port that is not held drives zero.
- R8: A release on a holding inbound port raises `relOut` on its outbound port in the next cycle and frees that port, so a request arriving in the following cycle can be granted. A request for that port arriving in the same cycle as the release is still refused.
- R9: When several inbound ports contend for one free outbound port, a round-robin order picks one winner, starting after the last winner (after index 3 following reset). Every loser gets a reject.
- R10: Different outbound ports grant in the same cycle independently of each other.
- R11: A request on an inbound port that already holds a path is ignored: it is neither forwarded nor rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| localAddr | input | ADDR_W | This node's number |
| peRoute | input | 2 | Outbound choice for a local-element request |
| reqIn | input | 4 | Request strobe per inbound port (0 left, 1 right, 2 across, 3 local) |
| relIn | input | 4 | Release strobe per inbound port |
| dataIn | input | 4 x DATA_W | Address during setup, then payload, per inbound port |
| dnAckIn | input | 4 | Accept from downstream per outbound port |
| dnRejIn | input | 4 | Reject from downstream per outbound port |
| reqOut | output | 4 | Request strobe per outbound port |
| relOut | output | 4 | Release strobe per outbound port |
| dataOut | output | 4 x DATA_W | Data per outbound port |
| upAckOut | output | 4 | Accept sent back on each inbound port |
| upRejOut | output | 4 | Reject sent back on each inbound port |

## Verification
Two events can land on the same outbound port in one cycle: a release that frees it and a new request that claims it. The bench drives both in the same cycle and expects the release to go out while the request is refused. It then repeats the request one cycle later and expects it to be granted with its address. Contention is provoked in the same way, by two inbound ports claiming the right output in one cycle twice in a row. Here the winner must alternate and the loser must see a reject in the same cycle as the winner's forwarded request.

// File: rtl/ring_cs_pkg.sv
package ring_cs_pkg;
  localparam int NCH   = 4;
  localparam int IDX_W = $clog2(NCH);

  typedef enum logic [IDX_W-1:0] {
    CH_LEFT   = 2'd0,
    CH_RIGHT  = 2'd1,
    CH_ACROSS = 2'd2,
    CH_LOCAL  = 2'd3
  } chan_e;

  // strobes from control to datapath: which inbound feeds each outbound
  typedef struct packed {
    logic [NCH-1:0]            selValid;
    logic [NCH-1:0][IDX_W-1:0] selSrc;
  } dp_ctrl_t;
endpackage

// File: rtl/ring_cs_ctrl.sv
module ring_cs_ctrl
  import ring_cs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          localAddr,
  input  logic [1:0]                 peRoute,
  input  logic [NCH-1:0]             reqIn,
  input  logic [NCH-1:0]             relIn,
  input  logic [NCH-1:0][DATA_W-1:0] dataIn,
  input  logic [NCH-1:0]             dnAckIn,
  input  logic [NCH-1:0]             dnRejIn,
  output logic [NCH-1:0]             reqOut,
  output logic [NCH-1:0]             relOut,
  output logic [NCH-1:0]             upAckOut,
  output logic [NCH-1:0]             upRejOut,
  output dp_ctrl_t                   dpCtrl
);
  logic [NCH-1:0]            lockValid;
  logic [NCH-1:0][IDX_W-1:0] lockSrc;
  logic [NCH-1:0][IDX_W-1:0] lastWin;

  logic [NCH-1:0]            isLocal, tgtValid, owned, reqV;
  logic [NCH-1:0][IDX_W-1:0] tgt;
  logic [NCH-1:0]            foundV, grantV, granted, rejNow;
  logic [NCH-1:0][IDX_W-1:0] winIdx;
  logic [IDX_W-1:0]          scanIdx;

  // distributors: decode destination per inbound port
  always_comb begin
    for (int i = 0; i < NCH; i++) isLocal[i] = (dataIn[i][ADDR_W-1:0] == localAddr);
    tgtValid = '1;
    tgt[CH_LEFT]   = isLocal[CH_LEFT]   ? CH_LOCAL : CH_RIGHT;
    tgt[CH_RIGHT]  = isLocal[CH_RIGHT]  ? CH_LOCAL : CH_LEFT;
    tgt[CH_ACROSS] = isLocal[CH_ACROSS] ? CH_LOCAL : CH_RIGHT;
    tgt[CH_LOCAL]  = peRoute;
    tgtValid[CH_LOCAL] = (peRoute != CH_LOCAL);
    owned = '0;
    for (int o = 0; o < NCH; o++)
      if (lockValid[o]) owned[lockSrc[o]] = 1'b1;
    reqV = reqIn & ~owned & tgtValid;
  end

  // allocators: round robin per outbound port
  always_comb begin
    foundV  = '0;
    winIdx  = '0;
    scanIdx = '0;
    for (int o = 0; o < NCH; o++) begin
      for (int k = 1; k <= NCH; k++) begin
        scanIdx = IDX_W'(lastWin[o] + IDX_W'(k));
        if (!foundV[o] && reqV[scanIdx] && tgt[scanIdx] == IDX_W'(o)) begin
          foundV[o] = 1'b1;
          winIdx[o] = scanIdx;
        end
      end
    end
    grantV  = foundV & ~lockValid;
    granted = '0;
    for (int o = 0; o < NCH; o++)
      if (grantV[o]) granted[winIdx[o]] = 1'b1;
    rejNow = reqIn & ~owned & ~granted;
  end

  // retain: locks, strobes and backward answers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockValid <= '0;
      lockSrc   <= '0;
      lastWin   <= '1;
      reqOut    <= '0;
      relOut    <= '0;
      upAckOut  <= '0;
      upRejOut  <= '0;
    end else begin
      reqOut   <= grantV;
      relOut   <= '0;
      upAckOut <= '0;
      upRejOut <= rejNow;
      for (int o = 0; o < NCH; o++) begin
        if (lockValid[o]) begin
          if (dnAckIn[o]) upAckOut[lockSrc[o]] <= 1'b1;
          if (dnRejIn[o]) begin
            upRejOut[lockSrc[o]] <= 1'b1;
            lockValid[o] <= 1'b0;
          end
          if (relIn[lockSrc[o]]) begin
            relOut[o]    <= 1'b1;
            lockValid[o] <= 1'b0;
          end
        end else if (grantV[o]) begin
          lockValid[o] <= 1'b1;
          lockSrc[o]   <= winIdx[o];
          lastWin[o]   <= winIdx[o];
        end
      end
    end
  end

  always_comb begin
    for (int o = 0; o < NCH; o++) begin
      dpCtrl.selValid[o] = lockValid[o] | grantV[o];
      dpCtrl.selSrc[o]   = lockValid[o] ? lockSrc[o] : winIdx[o];
    end
  end

  for (genvar o = 0; o < NCH; o++) begin : g_outChk
    AST_REQ_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
      reqOut[o] |-> lockValid[o]); // R5
    AST_REL_FREES_PORT: assert property (@(posedge clk) disable iff (!rstN)
      relOut[o] |-> !lockValid[o]); // R8
  end

  for (genvar i = 0; i < NCH; i++) begin : g_inChk
    logic [NCH-1:0] holdVec;
    always_comb
      for (int o = 0; o < NCH; o++) holdVec[o] = lockValid[o] && lockSrc[o] == IDX_W'(i);
    AST_ONE_PATH_PER_INPUT: assert property (@(posedge clk) disable iff (!rstN)
      $countones(holdVec) <= 1); // R11
    AST_ANSWER_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
      !(upAckOut[i] && upRejOut[i])); // R6
  end
endmodule

// File: rtl/ring_cs_dp.sv
module ring_cs_dp
  import ring_cs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dp_ctrl_t                   dpCtrl,
  input  logic [NCH-1:0][DATA_W-1:0] dataIn,
  output logic [NCH-1:0][DATA_W-1:0] dataOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataOut <= '0;
    else
      for (int o = 0; o < NCH; o++)
        dataOut[o] <= dpCtrl.selValid[o] ? dataIn[dpCtrl.selSrc[o]] : '0;
  end

  for (genvar o = 0; o < NCH; o++) begin : g_dpChk
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !dpCtrl.selValid[o] |=> dataOut[o] == '0); // R7
  end
endmodule

// File: rtl/ring_cs_switch.sv
module ring_cs_switch
  import ring_cs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          localAddr,
  input  logic [1:0]                 peRoute,
  input  logic [NCH-1:0]             reqIn,
  input  logic [NCH-1:0]             relIn,
  input  logic [NCH-1:0][DATA_W-1:0] dataIn,
  input  logic [NCH-1:0]             dnAckIn,
  input  logic [NCH-1:0]             dnRejIn,
  output logic [NCH-1:0]             reqOut,
  output logic [NCH-1:0]             relOut,
  output logic [NCH-1:0][DATA_W-1:0] dataOut,
  output logic [NCH-1:0]             upAckOut,
  output logic [NCH-1:0]             upRejOut
);
  dp_ctrl_t dpCtrl;

  ring_cs_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .localAddr(localAddr), .peRoute(peRoute),
    .reqIn(reqIn), .relIn(relIn), .dataIn(dataIn),
    .dnAckIn(dnAckIn), .dnRejIn(dnRejIn),
    .reqOut(reqOut), .relOut(relOut),
    .upAckOut(upAckOut), .upRejOut(upRejOut), .dpCtrl(dpCtrl)
  );

  ring_cs_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: tb/ring_cs_switch_tb_top.sv
module ring_cs_switch_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DW = 16;
  localparam int AW = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [AW-1:0]     localAddr = AW'(5);
  logic [1:0]        peRoute = '0;
  logic [3:0]        reqIn = '0, relIn = '0, dnAckIn = '0, dnRejIn = '0;
  logic [3:0][DW-1:0] dataIn = '0;
  logic [3:0]        reqOut, relOut, upAckOut, upRejOut;
  logic [3:0][DW-1:0] dataOut;

  ring_cs_switch #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .localAddr(localAddr), .peRoute(peRoute),
    .reqIn(reqIn), .relIn(relIn), .dataIn(dataIn),
    .dnAckIn(dnAckIn), .dnRejIn(dnRejIn),
    .reqOut(reqOut), .relOut(relOut), .dataOut(dataOut),
    .upAckOut(upAckOut), .upRejOut(upRejOut)
  );

  always #2.5 clk = ~clk;

  // kinds: 0 reqOut, 1 relOut, 2 upAckOut, 3 upRejOut, 4 data, 5 quiet cycle
  typedef struct {
    int          cyc;
    int          kind;
    int          port;
    logic [DW-1:0] val;
    string       tag;
  } ev_t;

  ev_t   evQ[$];
  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    done = 1'b0;
  bit    monOn = 1'b0;

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic expectEv(int kind, int port, int val, string tag);
    ev_t e;
    e.cyc = cyc + 1; e.kind = kind; e.port = port; e.val = DW'(val); e.tag = tag;
    evQ.push_back(e);
  endtask

  task automatic nextCycle();
    @(negedge clk);
    reqIn = '0; relIn = '0; dnAckIn = '0; dnRejIn = '0; dataIn = '0; peRoute = '0;
  endtask

  task automatic sendReq(int port, int dest);
    reqIn[port] = 1'b1;
    dataIn[port] = DW'(dest);
  endtask

  // monitor: pops this cycle's expectations and compares
  logic [3:0] expM [4];
  string      expT [4];
  bit         forceCmp;
  string      forceTag;
  logic [3:0] actV;
  always @(negedge clk) begin
    if (monOn) begin
      for (int k = 0; k < 4; k++) begin expM[k] = '0; expT[k] = "R2"; end
      forceCmp = 1'b0;
      forceTag = "";
      for (int j = evQ.size() - 1; j >= 0; j--) begin
        if (evQ[j].cyc == cyc) begin
          if (evQ[j].kind == 4)
            check(dataOut[evQ[j].port] == evQ[j].val, evQ[j].tag, "dataOut",
                  int'(dataOut[evQ[j].port]), int'(evQ[j].val));
          else if (evQ[j].kind == 5) begin
            forceCmp = 1'b1; forceTag = evQ[j].tag;
          end else begin
            expM[evQ[j].kind][evQ[j].port] = 1'b1;
            expT[evQ[j].kind] = evQ[j].tag;
          end
          evQ.delete(j);
        end
      end
      for (int k = 0; k < 4; k++) begin
        case (k)
          0: actV = reqOut;
          1: actV = relOut;
          2: actV = upAckOut;
          default: actV = upRejOut;
        endcase
        if (forceCmp || expM[k] != 0 || actV != 0)
          check(actV == expM[k], forceCmp && expM[k] == 0 ? forceTag : expT[k],
                $sformatf("strobe kind %0d", k), int'(actV), int'(expM[k]));
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(reqOut == 0 && relOut == 0, "R1", "req/rel after reset", int'({reqOut, relOut}), 0);
    check(upAckOut == 0 && upRejOut == 0, "R1", "ack/rej after reset", int'({upAckOut, upRejOut}), 0);
    check(dataOut == '0, "R1", "data after reset", int'(dataOut[1]), 0);
    monOn = 1'b1;

    // R3 R5: left request to node 7 leaves on right with its address
    nextCycle(); sendReq(0, 7);
    expectEv(0, 1, 0, "R5"); expectEv(4, 1, 7, "R3");
    // R7: payload passes through
    nextCycle(); dataIn[0] = 16'hABCD; expectEv(4, 1, 16'hABCD, "R7");
    // R6: downstream accept relayed to left inbound
    nextCycle(); dnAckIn[1] = 1'b1; expectEv(2, 0, 0, "R6");
    // R4: across request for busy right output refused
    nextCycle(); sendReq(2, 9); expectEv(3, 2, 0, "R4");
    // R8: release and competing request in one cycle
    nextCycle(); relIn[0] = 1'b1; sendReq(2, 9);
    expectEv(1, 1, 0, "R8"); expectEv(3, 2, 0, "R8");
    nextCycle(); sendReq(2, 9); expectEv(0, 1, 0, "R8"); expectEv(4, 1, 9, "R8");
    // R6: downstream reject relayed to across and frees port
    nextCycle(); dnRejIn[1] = 1'b1; expectEv(3, 2, 0, "R6");
    // R2 R10: local delivery and local-element left route in one cycle
    nextCycle(); sendReq(1, 5); sendReq(3, 3); peRoute = 2'd0;
    expectEv(0, 3, 0, "R2"); expectEv(4, 3, 5, "R2");
    expectEv(0, 0, 0, "R10"); expectEv(4, 0, 3, "R10");
    // R11: right inbound already holds a path, new request ignored
    nextCycle(); sendReq(1, 7); expectEv(5, 0, 0, "R11");
    // R8: both paths released
    nextCycle(); relIn[1] = 1'b1; relIn[3] = 1'b1;
    expectEv(1, 3, 0, "R8"); expectEv(1, 0, 0, "R8");
    // R9: contention, left wins after across was last winner
    nextCycle(); sendReq(0, 7); sendReq(2, 9);
    expectEv(0, 1, 0, "R9"); expectEv(4, 1, 7, "R9"); expectEv(3, 2, 0, "R9");
    nextCycle(); relIn[0] = 1'b1; expectEv(1, 1, 0, "R8");
    // R9: contention again, across wins now
    nextCycle(); sendReq(0, 7); sendReq(2, 9);
    expectEv(0, 1, 0, "R9"); expectEv(4, 1, 9, "R9"); expectEv(3, 0, 0, "R9");
    // R3: local route code 3 refused, code 2 goes across
    nextCycle(); sendReq(3, 1); peRoute = 2'd3; expectEv(3, 3, 0, "R3");
    nextCycle(); sendReq(3, 1); peRoute = 2'd2;
    expectEv(0, 2, 0, "R3"); expectEv(4, 2, 1, "R3");
    // R7: after release the right output drives zero
    nextCycle(); relIn[2] = 1'b1; expectEv(1, 1, 0, "R8");
    nextCycle(); dataIn[2] = 16'h1234; expectEv(4, 1, 0, "R7");
    repeat (3) nextCycle();
    check(evQ.size() == 0, "R2", "pending expectations", evQ.size(), 0);
    finishRun();
  end
endmodule